// File: doc/BRIEF.md
# Horizontal Correction Point Sequencer

This block drives three 6-bit correction data buses, one per colour, in step with the horizontal line sync. When it sees the front edge of the sync it waits a programmable number of system clocks. It then walks a programmable window of horizontal grid columns. Each column's value is supplied from outside, already interpolated in the vertical direction. The block holds that value unchanged for a programmable number of clocks and then moves to the next column. There is no interpolation between neighbouring columns. A one-cycle strobe marks every change of the output word, so a downstream converter can latch it.

The internal clock can run at the full input clock rate or at half that rate. Half rate is built as a clock enable on a single clock domain. The column walk can run in ascending or descending order, and the direction is taken either from a pin or from a register bit. A bypass forces a fixed off-level onto all three buses. The bypass applies when correction is switched off and while a configuration transfer is in progress. A standby code freezes the sequencer. An output-limit input and standby both drop the pad enable of the data buses, which puts the pads into high impedance.

Top module: `hcorr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `data0`..`data2` clear to 0 and `dac_stb` clears to 0.
- R2: With `sync_pol` = 1 a rising edge of `sync_in` starts a line. With `sync_pol` = 0 a falling edge starts a line.
- R3: If the front edge is detected at enabled edge k, the first column's values appear at enabled edge k + `start_dly`. Before that edge the buses carry `off_level`.
- R4: Each column's value is held for exactly `hold_len` + 1 enabled cycles, with no interpolation. `dac_stb` is high for one enabled cycle at every change of the output word: each column load, and the return to `off_level` after the last column.
- R5: Only columns `col_first` to `col_last` are output. The normal order is ascending. Column i of bus c is taken from bits [6i+5:6i] of `colv<c>`.
- R6: The effective direction bit is `lr_ext` when `lr_ext_sel` = 1 and `lr_reg` otherwise. A value of 0 walks from `col_last` down to `col_first`. The bit is sampled at the front edge, so changing it during a line has no effect on that line.
- R7: After the last column has been held, all buses carry `off_level` until the next front edge.
- R8: While `corr_on` = 0 or `xfer_busy` = 1, all three buses carry `off_level` from the next enabled edge onward. Clearing the condition restores the current column's value at the next enabled edge.
- R9: With `half_sel` = 1 only every second clock edge is enabled. Column pitch becomes 2(`hold_len`+1) clocks, and `dac_stb` stays high for two clocks.
- R10: While `stby_mode` = 2'b10 the sequencer is frozen, `dac_stb` is 0 and `data_oe` is 0. After standby is released the line continues from where it stopped.
- R11: `data_oe` is 0 while `out_lim` = 1 and 1 while `out_lim` = 0 (outside standby).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_sel | input | 1 | 1: internal rate is half the input clock |
| sync_in | input | 1 | Horizontal line sync |
| sync_pol | input | 1 | Sync polarity, 1 = positive |
| start_dly | input | 8 | Clocks from sync front edge to first column |
| hold_len | input | 8 | Column hold length minus one |
| col_first | input | 4 | Lowest column used |
| col_last | input | 4 | Highest column used |
| lr_ext | input | 1 | Direction from pin, 0 = reversed |
| lr_ext_sel | input | 1 | 1: use `lr_ext`, 0: use `lr_reg` |
| lr_reg | input | 1 | Direction from register, 0 = reversed |
| corr_on | input | 1 | 0: bypass to off-level |
| xfer_busy | input | 1 | 1: configuration transfer active, bypass |
| off_level | input | 6 | Fixed level used when not correcting |
| stby_mode | input | 2 | 2'b10 selects standby |
| out_lim | input | 1 | 1: data pads disabled |
| colv0 | input | 96 | Column values for bus 0 |
| colv1 | input | 96 | Column values for bus 1 |
| colv2 | input | 96 | Column values for bus 2 |
| data0 | output | 6 | Correction data bus 0 |
| data1 | output | 6 | Correction data bus 1 |
| data2 | output | 6 | Correction data bus 2 |
| data_oe | output | 1 | Pad enable for the data buses |
| dac_stb | output | 1 | Converter latch strobe |

## Verification
The bypass and the column step can fall in the same cycle. This happens when a transfer starts just as a column's hold ends. Standby and the column step can also coincide, and a freeze must not lose or repeat a step. The bench raises the transfer flag a few cycles into the first column. It checks that the off-level arrives on the next edge and that the column value returns one edge after the flag drops. It then enters standby partway through a hold and holds it for ten cycles. The next strobe is judged to arrive exactly ten cycles later than it would have without the freeze, carrying the next column's values.

// File: rtl/hcs_pkg.sv
// Package: shared types and constants for the horizontal correction sequencer.
// Assumes three colour channels; the standby code is fixed by the register layout.
package hcs_pkg;
    localparam int NCH = 3;
    localparam logic [1:0] STBY_CODE = 2'b10;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_RUN   = 2'd2
    } phase_t;
endpackage

// File: rtl/hcs_clk_en.sv
// Module: builds the internal-rate clock enable on the single input clock.
// Assumes half_sel changes only while the line sequencer is idle.
module hcs_clk_en (
    input  logic clk,
    input  logic rst_n,
    input  logic half_sel,
    input  logic freeze,
    output logic run_en
);
    logic div_q;

    // Toggle the phase bit in half-rate mode, park it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= 1'b0;
        else if (!half_sel) div_q <= 1'b0;
        else               div_q <= ~div_q;
    end

    // Enabled cycles: every cycle, or every second one; none while frozen.
    assign run_en = (half_sel ? div_q : 1'b1) && !freeze;
endmodule

// File: rtl/hcs_sync_edge.sv
// Module: normalises the line sync polarity and flags its front edge.
// Assumes the sync pulse lasts at least two enabled cycles.
module hcs_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sync_in,
    input  logic pol,
    output logic front
);
    logic act;
    logic prev_q;

    assign act = pol ? sync_in : ~sync_in;

    // Remember the active level seen at the last enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n)  prev_q <= 1'b1;
        else if (en) prev_q <= act;
    end

    assign front = en && act && !prev_q;
endmodule

// File: rtl/hcs_col_seq.sv
// Module: start delay, column hold and column stepping for one line.
// Exposes next-state column and phase so the output register can align with
// the strobe. Assumes col_first <= col_last, start_dly >= 1.
module hcs_col_seq
    import hcs_pkg::*;
#(
    parameter int CW = 4,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          front,
    input  logic [TW-1:0] start_dly,
    input  logic [TW-1:0] hold_len,
    input  logic [CW-1:0] col_first,
    input  logic [CW-1:0] col_last,
    input  logic          rev_in,
    output phase_t        phase_q,
    output phase_t        phase_n,
    output logic [CW-1:0] col_q,
    output logic [CW-1:0] col_n,
    output logic          load
);
    logic [TW-1:0] dly_q, dly_n;
    logic [TW-1:0] hold_q, hold_n;
    logic          rev_q, rev_n;
    logic [CW-1:0] end_col;

    assign end_col = rev_q ? col_first : col_last;

    // Next-state logic for delay, hold and column walk.
    always_comb begin
        phase_n = phase_q;
        dly_n   = dly_q;
        hold_n  = hold_q;
        col_n   = col_q;
        rev_n   = rev_q;
        load    = 1'b0;
        if (front) begin
            phase_n = PH_DELAY;
            dly_n   = {{(TW-1){1'b0}}, 1'b1};
            rev_n   = rev_in;
        end else begin
            case (phase_q)
                PH_DELAY: begin
                    if (dly_q == start_dly) begin
                        phase_n = PH_RUN;
                        col_n   = rev_q ? col_last : col_first;
                        hold_n  = '0;
                        load    = 1'b1;
                    end else begin
                        dly_n = dly_q + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (hold_q == hold_len) begin
                        load   = 1'b1;
                        hold_n = '0;
                        if (col_q == end_col) phase_n = PH_IDLE;
                        else col_n = rev_q ? col_q - 1'b1 : col_q + 1'b1;
                    end else begin
                        hold_n = hold_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Sequencer state advances only on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            dly_q   <= '0;
            hold_q  <= '0;
            col_q   <= '0;
            rev_q   <= 1'b0;
        end else if (en) begin
            phase_q <= phase_n;
            dly_q   <= dly_n;
            hold_q  <= hold_n;
            col_q   <= col_n;
            rev_q   <= rev_n;
        end
    end
endmodule

// File: rtl/hcorr_seq.sv
// Module: top of the horizontal correction point sequencer. Selects the
// per-column value for each colour bus, applies bypass, registers the buses
// and the converter strobe, and drives the pad enable.
// Assumes configuration inputs change only between lines.
module hcorr_seq
    import hcs_pkg::*;
#(
    parameter int NCOL = 16,
    parameter int DW   = 6,
    parameter int TW   = 8,
    localparam int CW  = $clog2(NCOL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               half_sel,
    input  logic               sync_in,
    input  logic               sync_pol,
    input  logic [TW-1:0]      start_dly,
    input  logic [TW-1:0]      hold_len,
    input  logic [CW-1:0]      col_first,
    input  logic [CW-1:0]      col_last,
    input  logic               lr_ext,
    input  logic               lr_ext_sel,
    input  logic               lr_reg,
    input  logic               corr_on,
    input  logic               xfer_busy,
    input  logic [DW-1:0]      off_level,
    input  logic [1:0]         stby_mode,
    input  logic               out_lim,
    input  logic [NCOL*DW-1:0] colv0,
    input  logic [NCOL*DW-1:0] colv1,
    input  logic [NCOL*DW-1:0] colv2,
    output logic [DW-1:0]      data0,
    output logic [DW-1:0]      data1,
    output logic [DW-1:0]      data2,
    output logic               data_oe,
    output logic               dac_stb
);
    logic          standby;
    logic          run_en;
    logic          front;
    logic          rev_in;
    logic          byp;
    logic          load;
    logic          phase_run;
    phase_t        phase_q, phase_n;
    logic [CW-1:0] col_cur, col_n;
    logic [NCOL*DW-1:0] vall  [NCH];
    logic [DW-1:0]      sel   [NCH];
    logic [DW-1:0]      dat_q [NCH];
    logic               stb_q;

    assign standby = (stby_mode == STBY_CODE);
    assign rev_in  = lr_ext_sel ? ~lr_ext : ~lr_reg;
    assign byp     = !corr_on || xfer_busy;

    hcs_clk_en u_ce (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_sel (half_sel),
        .freeze   (standby),
        .run_en   (run_en)
    );

    hcs_sync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (run_en),
        .sync_in (sync_in),
        .pol     (sync_pol),
        .front   (front)
    );

    hcs_col_seq #(.CW(CW), .TW(TW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (run_en),
        .front     (front),
        .start_dly (start_dly),
        .hold_len  (hold_len),
        .col_first (col_first),
        .col_last  (col_last),
        .rev_in    (rev_in),
        .phase_q   (phase_q),
        .phase_n   (phase_n),
        .col_q     (col_cur),
        .col_n     (col_n),
        .load      (load)
    );

    assign phase_run = (phase_q == PH_RUN);

    assign vall[0] = colv0;
    assign vall[1] = colv1;
    assign vall[2] = colv2;

    // One column-value selector per colour channel.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign sel[ch] = vall[ch][col_n*DW +: DW];
    end

    // Register the buses from next state so data and strobe change together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int ch = 0; ch < NCH; ch++) dat_q[ch] <= '0;
        end else if (run_en) begin
            for (int ch = 0; ch < NCH; ch++)
                dat_q[ch] <= (byp || phase_n != PH_RUN) ? off_level : sel[ch];
        end
    end

    // Strobe: one enabled cycle per output update, cleared in standby.
    always_ff @(posedge clk) begin
        if (!rst_n)      stb_q <= 1'b0;
        else if (standby) stb_q <= 1'b0;
        else if (run_en) stb_q <= load;
    end

    assign data0   = dat_q[0];
    assign data1   = dat_q[1];
    assign data2   = dat_q[2];
    assign dac_stb = stb_q;
    assign data_oe = !out_lim && !standby;
endmodule

// File: rtl/hcs_chk.sv
// Checker: temporal properties of the sequencer, bound into the top module.
module hcs_chk #(
    parameter int CW = 4,
    parameter int DW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_en,
    input logic          corr_on,
    input logic          xfer_busy,
    input logic [DW-1:0] off_level,
    input logic [1:0]    stby_mode,
    input logic [DW-1:0] d0,
    input logic          stb,
    input logic          run_phase,
    input logic [CW-1:0] col,
    input logic [CW-1:0] col_first,
    input logic [CW-1:0] col_last
);
    logic standby;
    assign standby = (stby_mode == 2'b10);

    // R5: a running column always lies inside the selected window.
    a_r5_col_window: assert property (@(posedge clk) disable iff (!rst_n)
        run_phase |-> (col >= col_first && col <= col_last));

    // R4: every column change is accompanied by the strobe.
    a_r4_step_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (run_phase && $past(run_phase) && col != $past(col)) |-> stb);

    // R8: a bypassed enabled edge loads the off-level.
    a_r8_bypass_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(run_en) && $past(!corr_on || xfer_busy))
        |-> (d0 == $past(off_level)));

    // R10: standby freezes the buses and silences the strobe.
    a_r10_standby_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(standby)) |-> ($stable(d0) && !stb));
endmodule

bind hcorr_seq hcs_chk #(.CW(CW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .corr_on   (corr_on),
    .xfer_busy (xfer_busy),
    .off_level (off_level),
    .stby_mode (stby_mode),
    .d0        (data0),
    .stb       (dac_stb),
    .run_phase (phase_run),
    .col       (col_cur),
    .col_first (col_first),
    .col_last  (col_last)
);

// File: tb/hcorr_seq_test.sv
`timescale 1ns/1ps
module hcorr_seq_test;
    localparam int NCOL = 16;
    localparam int DW   = 6;
    localparam int TW   = 8;
    localparam int CW   = 4;

    logic clk, rst_n, half_sel, sync_in, sync_pol;
    logic [TW-1:0] start_dly, hold_len;
    logic [CW-1:0] col_first, col_last;
    logic lr_ext, lr_ext_sel, lr_reg, corr_on, xfer_busy, out_lim;
    logic [DW-1:0] off_level;
    logic [1:0] stby_mode;
    logic [NCOL*DW-1:0] colv0, colv1, colv2;
    logic [DW-1:0] data0, data1, data2;
    logic data_oe, dac_stb;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    hcorr_seq uut (
        .clk(clk), .rst_n(rst_n), .half_sel(half_sel), .sync_in(sync_in),
        .sync_pol(sync_pol), .start_dly(start_dly), .hold_len(hold_len),
        .col_first(col_first), .col_last(col_last), .lr_ext(lr_ext),
        .lr_ext_sel(lr_ext_sel), .lr_reg(lr_reg), .corr_on(corr_on),
        .xfer_busy(xfer_busy), .off_level(off_level), .stby_mode(stby_mode),
        .out_lim(out_lim), .colv0(colv0), .colv1(colv1), .colv2(colv2),
        .data0(data0), .data1(data1), .data2(data2), .data_oe(data_oe),
        .dac_stb(dac_stb)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Vector fields: hp[28:21] hint[20:13] hb[12:9] he[8:5] src[4] pin[3] reg[2] pol[1] flip[0]
    localparam logic [28:0] VEC [6] = '{
        {8'd60,  8'd12, 4'd0, 4'd15, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {8'd55,  8'd13, 4'd0, 4'd15, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'd70,  8'd12, 4'd2, 4'd13, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
        {8'd56,  8'd20, 4'd5, 4'd5,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'd80,  8'd15, 4'd3, 4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'd255, 8'd12, 4'd0, 4'd15, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}
    };

    function automatic logic [5:0] cval(int ch, int i);
        return 6'((i * 3 + ch * 21 + 5) % 64);
    endfunction

    function automatic int trip(int i);
        return {cval(2, i), cval(1, i), cval(0, i)};
    endfunction

    function automatic int offv();
        return {off_level, off_level, off_level};
    endfunction

    function automatic int bus();
        return {data2, data1, data0};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cfg_std();
        start_dly = 8'd60; hold_len = 8'd12; col_first = 4'd0; col_last = 4'd15;
        lr_ext_sel = 1'b0; lr_ext = 1'b0; lr_reg = 1'b1; sync_pol = 1'b1; sync_in = 1'b0;
    endtask

    // Called at a negedge: raise sync; returns at front-edge clock (t origin).
    task automatic go_front();
        sync_in = sync_pol;
        @(posedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCOL; i++) begin
            colv0[i*DW +: DW] = cval(0, i);
            colv1[i*DW +: DW] = cval(1, i);
            colv2[i*DW +: DW] = cval(2, i);
        end
        rst_n = 1'b0; half_sel = 1'b0; corr_on = 1'b1; xfer_busy = 1'b0;
        out_lim = 1'b0; off_level = 6'h2A; stby_mode = 2'b00;
        cfg_std();
        repeat (3) @(negedge clk);
        // R1: reset state of buses and strobe
        chk("R1 data", bus(), 0);
        chk("R1 strobe", dac_stb, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 idle level", bus(), offv());

        // Vector table walk: delay, order, window, polarity, direction latch
        for (int e = 0; e < 6; e++) begin
            logic [28:0] v;
            int hp, hint, hb, he, n, last, j, c, ex;
            bit rev, flip;
            string tag;
            v = VEC[e];
            hp = int'(v[28:21]); hint = int'(v[20:13]);
            hb = int'(v[12:9]); he = int'(v[8:5]);
            flip = v[0];
            start_dly = v[28:21]; hold_len = v[20:13];
            col_first = v[12:9]; col_last = v[8:5];
            lr_ext_sel = v[4]; lr_ext = v[3]; lr_reg = v[2];
            sync_pol = v[1]; sync_in = ~v[1];
            rev = v[4] ? !v[3] : !v[2];
            n = he - hb + 1;
            last = hp + n * (hint + 1);
            repeat (4) @(negedge clk);
            go_front();
            for (int t = 0; t <= last + 4; t++) begin
                @(negedge clk);
                if (t < hp) begin
                    ex = offv(); tag = "R3 before start";
                end else if (t < last) begin
                    j = (t - hp) / (hint + 1);
                    c = rev ? he - j : hb + j;
                    ex = trip(c);
                    tag = rev ? "R6 reversed column" : "R5 column value";
                    if (t == hp) tag = sync_pol ? "R3 first column" : "R2 negative sync start";
                end else begin
                    ex = offv(); tag = "R7 after last";
                end
                chk(tag, bus(), ex);
                chk("R4 strobe", dac_stb,
                    (t >= hp && t <= last && ((t - hp) % (hint + 1)) == 0) ? 1 : 0);
                if (t == 3) sync_in = ~sync_pol;
                if (flip && t == hp + 1) begin
                    lr_ext = ~lr_ext;
                    lr_reg = ~lr_reg;
                end
            end
        end

        // R11: output limit drops the pad enable
        @(negedge clk);
        cfg_std();
        out_lim = 1'b1; #1;
        chk("R11 limit high", data_oe, 0);
        out_lim = 1'b0; #1;
        chk("R11 limit low", data_oe, 1);

        // R8: transfer flag mid-column, then release
        repeat (4) @(negedge clk);
        go_front();
        for (int t = 0; t <= 60 + 2; t++) begin
            @(negedge clk);
            if (t == 3) sync_in = 1'b0;
        end
        xfer_busy = 1'b1;
        @(negedge clk);
        chk("R8 transfer bypass", bus(), offv());
        xfer_busy = 1'b0;
        @(negedge clk);
        chk("R8 transfer released", bus(), trip(0));
        repeat (300) @(negedge clk);

        // R8: correction off for a whole line
        corr_on = 1'b0;
        go_front();
        for (int t = 0; t <= 60 + 13; t++) begin
            @(negedge clk);
            if (t == 3) sync_in = 1'b0;
            if (t == 60 || t == 73) chk("R8 correction off", bus(), offv());
        end
        corr_on = 1'b1;
        repeat (300) @(negedge clk);

        // R10: standby partway through the first column
        go_front();
        for (int t = 0; t <= 63; t++) begin
            @(negedge clk);
            if (t == 3) sync_in = 1'b0;
        end
        begin
            int held, bad;
            held = bus(); bad = 0;
            stby_mode = 2'b10; #1;
            chk("R10 pads off", data_oe, 0);
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (bus() != held || dac_stb != 1'b0) bad++;
            end
            chk("R10 frozen cycles", bad, 0);
        end
        stby_mode = 2'b00; #1;
        chk("R10 pads back", data_oe, 1);
        for (int t = 74; t <= 83; t++) begin
            @(negedge clk);
            if (t == 82) chk("R10 no early step", dac_stb, 0);
            if (t == 83) begin
                chk("R10 resumed step", dac_stb, 1);
                chk("R10 resumed column", bus(), trip(1));
            end
        end
        repeat (300) @(negedge clk);

        // R9: half-rate internal clock
        half_sel = 1'b1;
        repeat (4) @(negedge clk);
        go_front();
        begin
            int t0;
            t0 = -1;
            for (int t = 0; t <= 160; t++) begin
                @(negedge clk);
                if (t == 3) sync_in = 1'b0;
                if (t0 < 0 && dac_stb) begin
                    t0 = t;
                    chk("R9 first column", bus(), trip(0));
                end
                if (t0 >= 0 && t == t0 + 1) chk("R9 strobe two clocks", dac_stb, 1);
                if (t0 >= 0 && t == t0 + 2) chk("R9 strobe ends", dac_stb, 0);
                if (t0 >= 0 && t == t0 + 25) chk("R9 no early step", dac_stb, 0);
                if (t0 >= 0 && t == t0 + 26) begin
                    chk("R9 step pitch", dac_stb, 1);
                    chk("R9 second column", bus(), trip(1));
                end
            end
            chk("R9 start delay", (t0 == 120 || t0 == 121) ? 1 : 0, 1);
        end
        repeat (700) @(negedge clk);
        half_sel = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule